// File: doc/BRIEF.md
# Descriptor-chain serial flash sequencer

This block runs serial flash command sequences without a processor driving each bus phase. Software first loads a table of sixteen 16-bit step descriptors through a simple write port. A single start pulse then names the first descriptor to run. The engine drops chip select and executes the steps one after another. For each step it sets the number of data lanes, chooses what to transmit, decides whether to capture received bytes, and decides whether to release chip select when the step ends. Each descriptor carries the index of the step that follows it. The sequence stops after the step that is flagged as final.

Transmit bytes come in on a valid/ready byte input. Received bytes leave on a byte output that is marked valid for one cycle. A step may take its byte count from an external length input, so a read can be sized for each request while the rest of the chain stays fixed. The serial clock rate is chosen when the sequence starts: a read-class sequence uses one 16-bit half-period value and any other sequence uses a second one. Both values sit in one 32-bit configuration word. Typical chains include a status poll (send an opcode, then read two bytes), a continuous-mode exit (send an all-ones byte, then clock several quad or dual cycles), and an addressed read that contains dummy clocks.

Top module: `flash_seq`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into entry `cfg_addr`. The descriptor fields are: bits [1:0] lane mode (0 = one lane, 1 = two lanes, 2 or 3 = four lanes); bits [3:2] transmit mode (0 = none, 1 = data from the byte input, 2 or 3 = all-ones); bit 4 receive capture; bit 5 release chip select at the end of the step; bits [10:6] byte count; bits [14:11] next index; bit 15 final step.
- R2: A `start` pulse while idle raises `busy` and runs the chain from `start_idx`, following each next index until a final step completes. `busy` then falls and `done` is high for exactly one cycle. A `start` while busy has no effect.
- R3: Bytes are shifted most significant bit first. One lane takes 8 clocks per byte on `io_out[0]`, two lanes take 4 clocks on `io_out[1:0]`, and four lanes take 2 clocks on `io_out[3:0]`.
- R4: Transmit mode "data" takes one byte per `tx_valid`/`tx_ready` handshake, and the serial clock stays low while no byte is offered. All-ones mode drives 1s without a handshake.
- R5: With receive capture set, each completed byte appears on `rx_byte` with `rx_valid` high for one cycle. No `rx_valid` is produced when capture is clear.
- R6: Chip select stays low from one step into the next when the release bit is clear. It goes high for at least one cycle after any step with the release bit set and after the final step. It is high whenever the block is idle.
- R7: A step with transmit mode 0 drives no data lane (`io_oe` = 0) during its clocks. Two byte units at four lanes give four dummy clocks.
- R8: A byte count of 0 takes the count from `ext_len`. An `ext_len` of 0 is executed as one byte.
- R9: The half-period of `sck` in clock cycles is `div_cfg[15:0]` when `is_read` is high at start, and `div_cfg[31:16]` otherwise. A value of 0 acts as 1.
- R10: After reset, `cs_n` = 1, and `sck`, `busy`, `done`, `tx_ready`, `rx_valid` and `io_oe` are all 0.
- R11: SPI mode 0 is used: `sck` rests low, `io_in` is sampled on each rising edge of `sck` (one lane reads `io_in[1]`, two lanes read `io_in[1:0]`, four lanes read `io_in[3:0]`), and outputs change only while `sck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor table write strobe |
| cfg_addr | input | 4 | Descriptor table entry to write |
| cfg_wdata | input | 16 | Descriptor value |
| start | input | 1 | Start pulse |
| start_idx | input | 4 | First descriptor of the chain |
| is_read | input | 1 | Selects the read-class clock divider |
| div_cfg | input | 32 | Two half-period values: read [15:0], other [31:16] |
| ext_len | input | 8 | Byte count used by steps whose count is 0 |
| tx_byte | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken on this edge if valid |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte valid, one cycle |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data lanes, output value |
| io_oe | output | 4 | Data lane output enables |
| io_in | input | 4 | Data lanes, input value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
Each serial bit is sampled on the rising edge of `sck`, which comes one half-period after the low phase begins. The bench therefore checks the wire at `sck` rising events. It records the lane values and enables and counts the edges, so bit checks do not depend on the exact cycle counts. The peripheral side advances `io_in` only after each rising edge, so each expected received byte is built from the lane values at known edge numbers. The byte is due on `rx_byte` with `rx_valid` in the cycle after the falling edge that closes it, and the bench captures it at a falling clock edge. `busy` falls in the same cycle that `done` rises, and `done` comes one cycle after the last chip-select release. The bench waits for `done` before it reads edge counts, release counts, handshake counts and high-phase cycle counts.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int IDX_W   = 4;
    localparam int UNITS_W = 5;

    localparam logic [1:0] LANE_X1 = 2'd0;
    localparam logic [1:0] LANE_X2 = 2'd1;

    localparam logic [1:0] TXM_NONE = 2'd0;
    localparam logic [1:0] TXM_DATA = 2'd1;

    typedef struct packed {
        logic               last;
        logic [IDX_W-1:0]   next;
        logic [UNITS_W-1:0] units;
        logic               release_cs;
        logic               rx_en;
        logic [1:0]         txm;
        logic [1:0]         lanes;
    } step_t;

    localparam int STEP_W = $bits(step_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_BYTE,
        ST_SHIFT,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/flash_seq_store.sv
module flash_seq_store
    import flash_seq_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  step_t         wdata,
    input  logic [AW-1:0] raddr,
    output step_t         rdata
);

    step_t table_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        step_t slot_d;

        always_comb begin
            slot_d = table_q[e];
            if (we && (waddr == AW'(e))) begin
                slot_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                table_q[e] <= '0;
            end else begin
                table_q[e] <= slot_d;
            end
        end
    end

    assign rdata = table_q[raddr];

endmodule

// File: rtl/flash_seq_lanes.sv
module flash_seq_lanes (
    input  logic [1:0] lanes,
    input  logic [7:0] tx_sr,
    input  logic [7:0] rx_sr,
    input  logic [3:0] io_in,
    output logic [3:0] lane_out,
    output logic [3:0] lane_mask,
    output logic [7:0] tx_sr_next,
    output logic [7:0] rx_sr_next,
    output logic [3:0] clks_per_byte
);

    always_comb begin
        case (lanes)
            2'd0: begin
                lane_out      = {3'b000, tx_sr[7]};
                lane_mask     = 4'b0001;
                tx_sr_next    = {tx_sr[6:0], 1'b0};
                rx_sr_next    = {rx_sr[6:0], io_in[1]};
                clks_per_byte = 4'd8;
            end
            2'd1: begin
                lane_out      = {2'b00, tx_sr[7:6]};
                lane_mask     = 4'b0011;
                tx_sr_next    = {tx_sr[5:0], 2'b00};
                rx_sr_next    = {rx_sr[5:0], io_in[1:0]};
                clks_per_byte = 4'd4;
            end
            default: begin
                lane_out      = tx_sr[7:4];
                lane_mask     = 4'b1111;
                tx_sr_next    = {tx_sr[3:0], 4'b0000};
                rx_sr_next    = {rx_sr[3:0], io_in};
                clks_per_byte = 4'd2;
            end
        endcase
    end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int LEN_W   = 8,
    parameter int DIV_W   = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [STEP_W-1:0] cfg_wdata,
    input  logic             start,
    input  logic [AW-1:0]    start_idx,
    input  logic             is_read,
    input  logic [2*DIV_W-1:0] div_cfg,
    input  logic [LEN_W-1:0] ext_len,
    input  logic [7:0]       tx_byte,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             sck,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    idx;
        step_t            step;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
        logic [LEN_W-1:0] bytes_left;
        logic [3:0]       clk_left;
        logic [7:0]       tsr;
        logic [7:0]       rsr;
        logic             sck;
        logic             cs_n;
        logic             busy;
        logic             done;
        logic             rxv;
    } seq_regs_t;

    seq_regs_t q, d;

    step_t            rd_step;
    logic [3:0]       lane_out, lane_mask, cpb;
    logic [7:0]       tsr_next, rsr_next;
    logic [DIV_W-1:0] div_pick;
    logic [LEN_W-1:0] len_pick;

    flash_seq_store #(.ENTRIES(ENTRIES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (step_t'(cfg_wdata)),
        .raddr (q.idx),
        .rdata (rd_step)
    );

    flash_seq_lanes u_lanes (
        .lanes         (q.step.lanes),
        .tx_sr         (q.tsr),
        .rx_sr         (q.rsr),
        .io_in         (io_in),
        .lane_out      (lane_out),
        .lane_mask     (lane_mask),
        .tx_sr_next    (tsr_next),
        .rx_sr_next    (rsr_next),
        .clks_per_byte (cpb)
    );

    always_comb begin
        div_pick = is_read ? div_cfg[DIV_W-1:0] : div_cfg[2*DIV_W-1:DIV_W];
        if (div_pick == '0) begin
            div_pick = DIV_W'(1);
        end
        len_pick = (rd_step.units == '0) ? ext_len : LEN_W'(rd_step.units);
        if (len_pick == '0) begin
            len_pick = LEN_W'(1);
        end
    end

    assign tx_ready = (q.st == ST_BYTE) && (q.step.txm == TXM_DATA);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.rxv  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.idx  = start_idx;
                    d.div  = div_pick;
                    d.busy = 1'b1;
                    d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                d.step       = rd_step;
                d.bytes_left = len_pick;
                d.cs_n       = 1'b0;
                d.st         = ST_BYTE;
            end
            ST_BYTE: begin
                d.clk_left = cpb;
                d.cnt      = '0;
                if (q.step.txm == TXM_DATA) begin
                    if (tx_valid) begin
                        d.tsr = tx_byte;
                        d.st  = ST_SHIFT;
                    end
                end else begin
                    d.tsr = (q.step.txm == TXM_NONE) ? 8'h00 : 8'hFF;
                    d.st  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (q.cnt == q.div - DIV_W'(1)) begin
                    d.cnt = '0;
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        d.rsr = rsr_next;
                    end else begin
                        d.sck = 1'b0;
                        d.tsr = tsr_next;
                        if (q.clk_left == 4'd1) begin
                            d.rxv = q.step.rx_en;
                            if (q.bytes_left == LEN_W'(1)) begin
                                if (q.step.release_cs || q.step.last) begin
                                    d.cs_n = 1'b1;
                                    d.st   = ST_GAP;
                                end else begin
                                    d.idx = q.step.next;
                                    d.st  = ST_LOAD;
                                end
                            end else begin
                                d.bytes_left = q.bytes_left - LEN_W'(1);
                                d.st         = ST_BYTE;
                            end
                        end else begin
                            d.clk_left = q.clk_left - 4'd1;
                        end
                    end
                end else begin
                    d.cnt = q.cnt + DIV_W'(1);
                end
            end
            ST_GAP: begin
                if (q.step.last) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.idx = q.step.next;
                    d.st  = ST_LOAD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck      = q.sck;
    assign cs_n     = q.cs_n;
    assign busy     = q.busy;
    assign done     = q.done;
    assign rx_valid = q.rxv;
    assign rx_byte  = q.rsr;
    assign io_out   = lane_out;
    assign io_oe    = (!q.cs_n && (q.st == ST_BYTE || q.st == ST_SHIFT)
                       && q.step.txm != TXM_NONE) ? lane_mask : 4'b0000;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       sck,
    input logic       cs_n,
    input logic [3:0] io_oe,
    input logic       busy,
    input logic       done
);

    AST_SCK_RESTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R11

    AST_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (io_oe == 4'b0000)); // R7

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R2

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy); // R2

    AST_STALL_HOLDS_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> !sck); // R4

    AST_RX_INSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy); // R5

    AST_READY_INSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (busy && !cs_n)); // R4

endmodule

bind flash_seq flash_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .sck      (sck),
    .cs_n     (cs_n),
    .io_oe    (io_oe),
    .busy     (busy),
    .done     (done)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [3:0]  start_idx = '0;
    logic        is_read = 1'b1;
    logic [31:0] div_cfg = {16'd1, 16'd1};
    logic [7:0]  ext_len = 8'd3;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        sck, cs_n, busy, done;
    logic [3:0]  io_out, io_oe, io_in;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic tx_gate = 1'b1;
    int   tx_ptr = 0;
    int   edges = 0;
    int   rel = 0;
    int   done_cnt = 0;
    int   rx_n = 0;
    int   hi_cyc = 0;
    logic [3:0] e_io [64];
    logic [3:0] e_oe [64];
    logic [7:0] rxbuf [32];

    always #4 clk = ~clk;

    function automatic logic [7:0] tx_val(int k);
        return 8'(k * 37 + 156);
    endfunction

    function automatic logic [3:0] pin_val(int k);
        return 4'(k * 7 + 3);
    endfunction

    function automatic logic [15:0] mk(int lanes, int txm, int rx, int rls,
                                       int units, int nxt, int last);
        return {1'(last), 4'(nxt), 5'(units), 1'(rls), 1'(rx), 2'(txm), 2'(lanes)};
    endfunction

    function automatic logic [7:0] rx_exp(int off, int w, int j);
        logic [7:0] b = '0;
        int c = 8 / w;
        for (int e = 0; e < c; e++) begin
            logic [3:0] p = pin_val(off + j * c + e);
            if (w == 1)      b = {b[6:0], p[1]};
            else if (w == 2) b = {b[5:0], p[1:0]};
            else             b = {b[3:0], p};
        end
        return b;
    endfunction

    assign tx_byte  = tx_val(tx_ptr);
    assign tx_valid = tx_gate;
    assign io_in    = pin_val(edges);

    flash_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .start_idx(start_idx),
        .is_read(is_read), .div_cfg(div_cfg), .ext_len(ext_len),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .sck(sck), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .busy(busy), .done(done)
    );

    always @(posedge clk) if (tx_valid && tx_ready) tx_ptr <= tx_ptr + 1;

    always @(posedge sck) begin
        if (!cs_n) begin
            if (edges < 64) begin
                e_io[edges] = io_out;
                e_oe[edges] = io_oe;
            end
            edges = edges + 1;
        end
    end

    always @(posedge cs_n) rel = rel + 1;

    always @(negedge clk) begin
        if (done) done_cnt = done_cnt + 1;
        if (sck) hi_cyc = hi_cyc + 1;
        if (rx_valid && rx_n < 32) begin
            rxbuf[rx_n] = rx_byte;
            rx_n = rx_n + 1;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear();
        @(negedge clk);
        edges = 0; rel = 0; done_cnt = 0; rx_n = 0; hi_cyc = 0;
        tx_ptr = 0;
    endtask

    task automatic wr(int a, logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic kick(int idx, logic rd);
        @(negedge clk);
        start = 1'b1; start_idx = 4'(idx); is_read = rd;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int c = 0; c < 4000 && done_cnt == 0; c++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // row: start index, edges, rx bytes, releases, tx handshakes, rx edge offset, rx lanes
    localparam int NROW = 5;
    localparam int V_IDX [NROW] = '{0, 2, 4, 6, 9};
    localparam int V_EDG [NROW] = '{24, 20, 24, 14, 16};
    localparam int V_RXN [NROW] = '{2, 9, 5, 3, 0};
    localparam int V_REL [NROW] = '{1, 1, 1, 1, 2};
    localparam int V_TXN [NROW] = '{1, 0, 0, 2, 2};
    localparam int V_OFF [NROW] = '{8, 2, 4, 8, 0};
    localparam int V_W   [NROW] = '{1, 4, 2, 4, 1};

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(cs_n == 1'b1 && sck == 1'b0, "R10", "cs_n/sck at reset", {cs_n, sck}, 2);
        check(!busy && !done && !tx_ready && !rx_valid && io_oe == 0, "R10",
              "idle outputs at reset", {busy, done, tx_ready, rx_valid}, 0);
        rst_n = 1'b1;

        // R1 table contents
        wr(0,  mk(0, 1, 0, 0, 1, 1, 0));  // status poll opcode
        wr(1,  mk(0, 0, 1, 1, 2, 0, 1));  // read two bytes
        wr(2,  mk(2, 2, 0, 0, 1, 3, 0));  // quad all-ones
        wr(3,  mk(2, 0, 1, 1, 9, 0, 1));  // quad read 9
        wr(4,  mk(1, 2, 0, 0, 1, 5, 0));  // dual all-ones
        wr(5,  mk(1, 0, 1, 1, 5, 0, 1));  // dual read 5
        wr(6,  mk(2, 1, 0, 0, 2, 7, 0));  // quad data 2
        wr(7,  mk(2, 0, 0, 0, 2, 8, 0));  // quad dummy
        wr(8,  mk(2, 0, 1, 1, 0, 0, 1));  // quad read, external length
        wr(9,  mk(0, 1, 0, 1, 1, 10, 0)); // release mid chain
        wr(10, mk(0, 1, 0, 1, 1, 0, 1));

        for (int r = 0; r < NROW; r++) begin
            int miss = 0;
            int first_bad = -1;
            clear();
            kick(V_IDX[r], 1'b1);
            wait_done();
            check(edges == V_EDG[r], "R1/R2/R3", $sformatf("row %0d sck edges", r), edges, V_EDG[r]);
            check(rx_n == V_RXN[r], "R5/R8", $sformatf("row %0d rx bytes", r), rx_n, V_RXN[r]);
            check(rel == V_REL[r], "R6", $sformatf("row %0d cs releases", r), rel, V_REL[r]);
            check(tx_ptr == V_TXN[r], "R4", $sformatf("row %0d tx handshakes", r), tx_ptr, V_TXN[r]);
            check(done_cnt == 1 && !busy && cs_n, "R2", $sformatf("row %0d done pulses", r), done_cnt, 1);
            for (int j = 0; j < V_RXN[r] && j < rx_n; j++) begin
                if (rxbuf[j] != rx_exp(V_OFF[r], V_W[r], j)) begin
                    miss++;
                    if (first_bad < 0) first_bad = j;
                end
            end
            check(miss == 0, "R5/R11", $sformatf("row %0d rx data", r),
                  (first_bad < 0) ? 0 : int'(rxbuf[first_bad]),
                  (first_bad < 0) ? 0 : int'(rx_exp(V_OFF[r], V_W[r], first_bad)));
        end

        // R3 one-lane opcode on io_out[0], MSB first
        begin
            logic [7:0] got = '0;
            logic [3:0] oe_or = '0;
            clear(); kick(0, 1'b1); wait_done();
            for (int e = 0; e < 8; e++) begin
                got = {got[6:0], e_io[e][0]};
                oe_or = oe_or | e_oe[e];
            end
            check(got == tx_val(0), "R3", "one-lane opcode bits", got, tx_val(0));
            check(oe_or == 4'b0001, "R3", "one-lane enable", oe_or, 1);
        end

        // R4 all-ones in four lanes, R7 dummy clocks, R3 four-lane data
        begin
            clear(); kick(2, 1'b1); wait_done();
            check(e_io[0] == 4'hF && e_io[1] == 4'hF && e_oe[0] == 4'hF, "R4",
                  "all-ones nibbles", {e_io[0], e_io[1]}, 8'hFF);
            clear(); kick(6, 1'b1); wait_done();
            check({e_io[0], e_io[1], e_io[2], e_io[3]} == {tx_val(0), tx_val(1)}, "R3",
                  "four-lane data", {e_io[0], e_io[1], e_io[2], e_io[3]}, {tx_val(0), tx_val(1)});
            check((e_oe[4] | e_oe[5] | e_oe[6] | e_oe[7]) == 4'b0000, "R7",
                  "dummy clocks undriven", e_oe[4] | e_oe[5] | e_oe[6] | e_oe[7], 0);
        end

        // R8 external length of zero runs one byte
        ext_len = 8'd0;
        clear(); kick(6, 1'b1); wait_done();
        check(rx_n == 1 && edges == 10, "R8", "zero external length", rx_n, 1);
        ext_len = 8'd3;

        // R4 stall while transmit byte missing
        tx_gate = 1'b0;
        clear(); kick(0, 1'b1);
        repeat (20) @(negedge clk);
        check(edges == 0 && busy && !cs_n, "R4", "stalled edges", edges, 0);
        tx_gate = 1'b1;
        wait_done();
        check(edges == 24, "R4", "edges after stall released", edges, 24);

        // R2 start while busy ignored
        clear(); kick(9, 1'b1);
        repeat (5) @(negedge clk);
        kick(0, 1'b1);
        wait_done();
        check(edges == 16 && rel == 2 && done_cnt == 1, "R2", "start while busy", edges, 16);

        // R9 divider selection
        div_cfg = {16'd2, 16'd3};
        clear(); kick(0, 1'b1); wait_done();
        check(hi_cyc == 72, "R9", "read divider high cycles", hi_cyc, 72);
        clear(); kick(0, 1'b0); wait_done();
        check(hi_cyc == 48, "R9", "other divider high cycles", hi_cyc, 48);
        div_cfg = {16'd0, 16'd0};
        clear(); kick(0, 1'b0); wait_done();
        check(hi_cyc == 24, "R9", "zero divider acts as one", hi_cyc, 24);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule